// File: doc/BRIEF.md
# Two-Channel Pulse Tally Unit

The block counts pulses on two input channels into one 16-bit signed tally. Each channel has a pulse line and a control line. All four lines first pass through a glitch filter that can be switched off. A rising or falling edge on a filtered pulse line asks for an increment, a decrement or nothing. The current level of the same channel's control line can then keep that request, reverse it or cancel it. When both channels act in the same cycle, their steps are added together.

The tally is watched against five points: two thresholds, a high limit, a low limit and zero. A watch point that is enabled and gets hit sets a sticky flag, and every flag feeds one shared interrupt. Reaching either limit returns the tally to zero in the next cycle. When the zero watch point fires, a 2-bit code records how zero was reached. Software drives the block through a small flat register interface. Writes complete in one cycle and reads are combinational.

The register addresses on `reg_addr_i` are:
- 0: configuration
- 1: thresholds (threshold 0 in [15:0], threshold 1 in [31:16])
- 2: limits (low in [15:0], high in [31:16])
- 3: control (clear in bit 0, pause in bit 1)
- 4: tally (read-only)
- 5: status (read-only)
- 6: interrupt enable (bit 0)
- 7: interrupt status (reads raw in bit 0 and masked in bit 1; writing 1 to bit 0 clears)

The configuration word holds:
- [9:0]: filter threshold
- [10]: filter enable
- [15:11]: watch enables, in the order threshold 1, threshold 0, low limit, high limit, zero
- [23:16]: channel 0 byte
- [31:24]: channel 1 byte

Each channel byte holds the rising-edge action in [1:0], the falling-edge action in [3:2], the control-high modifier in [5:4] and the control-low modifier in [7:6].

Top module: `pulse_tally_unit`

## Requirements
- R1: After reset, the tally reads 0, the status word reads 0, interrupt status reads 0 and `irq_o` is low.
- R2: The edge action codes are 0 = nothing, 1 = add one, 2 = subtract one. A rising edge on a filtered pulse line applies its channel's rising-edge action, and a falling edge applies its falling-edge action.
- R3: The modifier codes are 0 = keep, 1 = reverse (add and subtract swap), 2 = cancel. The modifier applied is the control-high one while that channel's filtered control line is 1, and the control-low one otherwise.
- R4: Steps from both channels in the same cycle are summed, so the tally moves by at most 2 per cycle.
- R5: With the filter enabled and threshold N, a level lasting fewer than N cycles on any input is ignored, and a level lasting N cycles or more passes. With the filter disabled, a single-cycle pulse is counted.
- R6: While pause (control bit 1) is 1, the tally holds. While clear (control bit 0) is 1, the tally is 0, even when pause is also set. Clear raises no watch event.
- R7: When the tally reaches the high limit, status bit 5 is set (if watch enable bit 14 is on) and the tally is 0 one cycle later.
- R8: When the tally reaches the low limit, status bit 4 is set (if watch enable bit 13 is on) and the tally is 0 one cycle later.
- R9: When the tally changes to a value equal to threshold 0, status bit 3 is set (enable bit 12). When it changes to a value equal to threshold 1, status bit 2 is set (enable bit 11).
- R10: The zero event (enable bit 15) sets status bit 6 and writes status[1:0] as follows:
  - 0: landed on zero from a positive value
  - 1: landed on zero from a negative value
  - 2: returned to zero by a limit reset
  - 3: jumped from one sign to the other without stopping at zero
- R11: A watch point whose enable bit is 0 sets no flag and does not raise the interrupt.
- R12: Any enabled watch event sets raw interrupt status. `irq_o` and the masked bit equal raw AND enable. Writing 1 to bit 0 of address 7 clears the raw bit and all status flags.
- R13: The tally reads back at address 4 sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 2 | Pulse line, one per channel |
| ctrl_i | input | 2 | Control line, one per channel |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Shared watch interrupt |

## Verification
The bench sweeps every edge action against every modifier and control level on both channels. A swapped code or an ignored control level shows up as a wrong tally. It drives pulses one cycle shorter than the filter threshold and pulses exactly at the threshold. An off-by-one filter counts the short pulse or drops the exact one. It steers the tally through both limits, both thresholds and all four ways of reaching zero. A design that misses the limit reset, fires on a disabled point or records the wrong zero code leaves a different status word. It also places a double step across zero, which a design that only tests for an exact zero never reports.

// File: rtl/pulse_tally_pkg.sv
`timescale 1ns/1ps
package pulse_tally_pkg;

  localparam int N_CH = 2;
  localparam int N_EV = 5;

  // watch event indices: enable bits and status flags follow this order
  localparam int EV_THR1 = 0;
  localparam int EV_THR0 = 1;
  localparam int EV_LOW  = 2;
  localparam int EV_HIGH = 3;
  localparam int EV_ZERO = 4;

  // register addresses
  localparam logic [2:0] A_CFG = 3'd0;
  localparam logic [2:0] A_THR = 3'd1;
  localparam logic [2:0] A_LIM = 3'd2;
  localparam logic [2:0] A_CTL = 3'd3;
  localparam logic [2:0] A_CNT = 3'd4;
  localparam logic [2:0] A_STA = 3'd5;
  localparam logic [2:0] A_IEN = 3'd6;
  localparam logic [2:0] A_IST = 3'd7;

  localparam int CFG_FEN_BIT = 10;
  localparam int CFG_EV_LSB  = 11;
  localparam int CFG_CH_LSB  = 16;
  localparam int CH_CFG_W    = 8;
  localparam int HALF_W      = 16;

  localparam logic [1:0] EDGE_HOLD  = 2'd0;
  localparam logic [1:0] EDGE_UP    = 2'd1;
  localparam logic [1:0] EDGE_DOWN  = 2'd2;
  localparam logic [1:0] LVL_KEEP   = 2'd0;
  localparam logic [1:0] LVL_INVERT = 2'd1;

  localparam logic [1:0] ZC_FROM_POS = 2'd0;
  localparam logic [1:0] ZC_FROM_NEG = 2'd1;
  localparam logic [1:0] ZC_LIMIT    = 2'd2;
  localparam logic [1:0] ZC_JUMP     = 2'd3;

  typedef struct packed {
    logic [1:0] lo_mod;
    logic [1:0] hi_mod;
    logic [1:0] fall_act;
    logic [1:0] rise_act;
  } chan_cfg_t;

  // step requested by one channel in one cycle, -1..+1
  function automatic logic signed [1:0] chan_step(input logic rise, input logic fall,
                                                  input chan_cfg_t c, input logic lvl);
    logic [1:0]        act;
    logic [1:0]        md;
    logic signed [1:0] v;
    act = rise ? c.rise_act : (fall ? c.fall_act : EDGE_HOLD);
    md  = lvl ? c.hi_mod : c.lo_mod;
    case (act)
      EDGE_UP:   v = 2'sd1;
      EDGE_DOWN: v = -2'sd1;
      default:   v = 2'sd0;
    endcase
    if (md == LVL_INVERT)    v = -v;
    else if (md != LVL_KEEP) v = 2'sd0;
    return v;
  endfunction

  function automatic logic [1:0] zc_code(input logic by_limit, input logic jumped,
                                         input logic was_neg);
    if (by_limit)    return ZC_LIMIT;
    else if (jumped) return ZC_JUMP;
    else if (was_neg) return ZC_FROM_NEG;
    return ZC_FROM_POS;
  endfunction

endpackage

// File: rtl/ptu_glitch_filter.sv
`timescale 1ns/1ps
module ptu_glitch_filter #(
  parameter int FILT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FILT_W-1:0] thres_i,
  input  logic              din_i,
  output logic              dout_o
);
  logic [FILT_W-1:0] run_q;
  logic [FILT_W:0]   run_nx;
  logic              settle;

  assign run_nx = {1'b0, run_q} + 1'b1;
  // new level accepted on the Nth consecutive differing sample
  assign settle = run_nx >= {1'b0, thres_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      dout_o <= 1'b0;
    end else if (!en_i) begin
      run_q  <= '0;
      dout_o <= din_i;
    end else if (din_i == dout_o) begin
      run_q <= '0;
    end else if (settle) begin
      run_q  <= '0;
      dout_o <= din_i;
    end else begin
      run_q <= run_nx[FILT_W-1:0];
    end
  end
endmodule

// File: rtl/ptu_chan_decode.sv
`timescale 1ns/1ps
module ptu_chan_decode
  import pulse_tally_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              level_i,
  input  chan_cfg_t         cfg_i,
  output logic signed [1:0] step_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pulse_i;
  end

  assign rise   = pulse_i & ~prev_q;
  assign fall   = ~pulse_i & prev_q;
  assign step_o = chan_step(rise, fall, cfg_i, level_i);
endmodule

// File: rtl/ptu_count_core.sv
`timescale 1ns/1ps
module ptu_count_core
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    pause_i,
  input  logic signed [2:0]       delta_i,
  input  logic signed [CNT_W-1:0] thr0_i,
  input  logic signed [CNT_W-1:0] thr1_i,
  input  logic signed [CNT_W-1:0] hi_i,
  input  logic signed [CNT_W-1:0] lo_i,
  input  logic [N_EV-1:0]         ev_en_i,
  input  logic                    int_clr_i,
  output logic signed [CNT_W-1:0] count_o,
  output logic [N_EV-1:0]         flags_o,
  output logic [1:0]              zc_mode_o,
  output logic [N_EV-1:0]         fire_o,
  output logic                    limit_reset_o
);
  localparam int MSB = CNT_W - 1;

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic                    limit_hit, moved, landed, jumped;
  logic [N_EV-1:0]         hit;

  always_comb begin
    limit_hit     = (cnt_q == hi_i) || (cnt_q == lo_i);
    limit_reset_o = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (limit_hit) begin
      cnt_d         = '0;
      limit_reset_o = 1'b1;
    end else if (pause_i) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(delta_i);
    end

    moved  = !clear_i && (cnt_d != cnt_q);
    landed = moved && (cnt_d == '0);
    jumped = moved && !limit_reset_o && (cnt_q != '0) && (cnt_d != '0)
             && (cnt_q[MSB] != cnt_d[MSB]);

    hit          = '0;
    hit[EV_THR1] = moved && (cnt_d == thr1_i);
    hit[EV_THR0] = moved && (cnt_d == thr0_i);
    hit[EV_LOW]  = moved && !limit_reset_o && (cnt_d == lo_i);
    hit[EV_HIGH] = moved && !limit_reset_o && (cnt_d == hi_i);
    hit[EV_ZERO] = landed || jumped;
    fire_o       = hit & ev_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      flags_o   <= '0;
      zc_mode_o <= ZC_FROM_POS;
    end else begin
      cnt_q   <= cnt_d;
      flags_o <= (int_clr_i ? '0 : flags_o) | fire_o;
      if (fire_o[EV_ZERO])
        zc_mode_o <= zc_code(limit_reset_o, jumped, cnt_q[MSB]);
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pulse_tally_unit.sv
`timescale 1ns/1ps
module pulse_tally_unit
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pulse_i,
  input  logic [N_CH-1:0] ctrl_i,
  input  logic [2:0]      reg_addr_i,
  input  logic            reg_wr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            irq_o
);
  localparam int N_IN = 2 * N_CH;
  localparam logic [31:0] LIM_RST = {HALF_W'({1'b0, {(CNT_W-1){1'b1}}}),
                                     HALF_W'({1'b1, {(CNT_W-1){1'b0}}})};

  logic [31:0] cfg_q, thr_q, lim_q;
  logic        clr_q, pause_q, ien_q, raw_q;
  logic        int_clr;

  // ---------------- register file ----------------
  assign int_clr = reg_wr_i && (reg_addr_i == A_IST) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      thr_q   <= '0;
      lim_q   <= LIM_RST;
      clr_q   <= 1'b0;
      pause_q <= 1'b0;
      ien_q   <= 1'b0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CFG: cfg_q <= reg_wdata_i;
        A_THR: thr_q <= reg_wdata_i;
        A_LIM: lim_q <= reg_wdata_i;
        A_CTL: begin
          clr_q   <= reg_wdata_i[0];
          pause_q <= reg_wdata_i[1];
        end
        A_IEN: ien_q <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  // ---------------- input filters ----------------
  logic [N_IN-1:0] raw_in, filt;
  assign raw_in = {ctrl_i, pulse_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_filt
    ptu_glitch_filter #(.FILT_W(FILT_W)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cfg_q[CFG_FEN_BIT]),
      .thres_i (cfg_q[FILT_W-1:0]),
      .din_i   (raw_in[i]),
      .dout_o  (filt[i])
    );
  end

  // ---------------- channel decode ----------------
  logic signed [1:0] step_c [N_CH];
  logic signed [2:0] delta_sum;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    ptu_chan_decode u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (filt[c]),
      .level_i (filt[N_CH + c]),
      .cfg_i   (chan_cfg_t'(cfg_q[CFG_CH_LSB + CH_CFG_W*c +: CH_CFG_W])),
      .step_o  (step_c[c])
    );
  end

  always_comb begin
    delta_sum = '0;
    for (int c = 0; c < N_CH; c++) delta_sum = delta_sum + 3'(step_c[c]);
  end

  // ---------------- counter and watch points ----------------
  logic signed [CNT_W-1:0] count, hi_lim, lo_lim;
  logic [N_EV-1:0]         flags, fire;
  logic [1:0]              zc_mode;
  logic                    limit_reset, any_fire, zero_fire;

  assign hi_lim = lim_q[HALF_W +: CNT_W];
  assign lo_lim = lim_q[CNT_W-1:0];

  ptu_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clr_q),
    .pause_i       (pause_q),
    .delta_i       (delta_sum),
    .thr0_i        (thr_q[CNT_W-1:0]),
    .thr1_i        (thr_q[HALF_W +: CNT_W]),
    .hi_i          (hi_lim),
    .lo_i          (lo_lim),
    .ev_en_i       (cfg_q[CFG_EV_LSB +: N_EV]),
    .int_clr_i     (int_clr),
    .count_o       (count),
    .flags_o       (flags),
    .zc_mode_o     (zc_mode),
    .fire_o        (fire),
    .limit_reset_o (limit_reset)
  );

  assign any_fire  = |fire;
  assign zero_fire = fire[EV_ZERO];

  // ---------------- shared interrupt ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= (raw_q && !int_clr) || any_fire;
  end

  assign irq_o = raw_q && ien_q;

  // ---------------- read mux ----------------
  always_comb begin
    case (reg_addr_i)
      A_CFG:   reg_rdata_o = cfg_q;
      A_THR:   reg_rdata_o = thr_q;
      A_LIM:   reg_rdata_o = lim_q;
      A_CTL:   reg_rdata_o = {30'd0, pause_q, clr_q};
      A_CNT:   reg_rdata_o = 32'(count);
      A_STA:   reg_rdata_o = 32'({flags, zc_mode});
      A_IEN:   reg_rdata_o = {31'd0, ien_q};
      default: reg_rdata_o = {30'd0, raw_q && ien_q, raw_q};
    endcase
  end
endmodule

// File: rtl/pulse_tally_checker.sv
`timescale 1ns/1ps
module ptu_checker
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [CNT_W-1:0] count,
  input logic signed [CNT_W-1:0] hi_lim,
  input logic signed [CNT_W-1:0] lo_lim,
  input logic                    clr_q,
  input logic                    pause_q,
  input logic                    limit_reset,
  input logic                    any_fire,
  input logic                    zero_fire,
  input logic [1:0]              zc_mode,
  input logic [N_EV-1:0]         flags,
  input logic                    int_clr,
  input logic                    raw_q,
  input logic                    ien_q,
  input logic                    irq_o
);
  logic signed [CNT_W-1:0] prev_cnt, step_seen;
  logic                    prev_clr, prev_lim, prev_pause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cnt   <= '0;
      prev_clr   <= 1'b0;
      prev_lim   <= 1'b0;
      prev_pause <= 1'b0;
    end else begin
      prev_cnt   <= count;
      prev_clr   <= clr_q;
      prev_lim   <= limit_reset;
      prev_pause <= pause_q;
    end
  end

  assign step_seen = count - prev_cnt;

  p_step_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_clr && !prev_lim) |-> (step_seen >= -2 && step_seen <= 2));

  p_pause_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_pause && !prev_clr && !prev_lim) |-> (count == prev_cnt));

  p_clear_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_clr |-> (count == '0));

  // covers R8 as well: either limit returns the tally to zero
  p_limit_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((count == hi_lim) || (count == lo_lim)) |=> (count == '0));

  p_zc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(zero_fire) |-> $stable(zc_mode));

  p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(int_clr) |-> ((flags & $past(flags)) == $past(flags)));

  p_irq_source_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(any_fire));

  p_irq_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_q);
endmodule

bind pulse_tally_unit ptu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .count       (count),
  .hi_lim      (hi_lim),
  .lo_lim      (lo_lim),
  .clr_q       (clr_q),
  .pause_q     (pause_q),
  .limit_reset (limit_reset),
  .any_fire    (any_fire),
  .zero_fire   (zero_fire),
  .zc_mode     (zc_mode),
  .flags       (flags),
  .int_clr     (int_clr),
  .raw_q       (raw_q),
  .ien_q       (ien_q),
  .irq_o       (irq_o)
);

// File: tb/pulse_tally_unit_tb_top.sv
`timescale 1ns/1ps
module pulse_tally_unit_tb_top;
  localparam logic [2:0] CFG = 3'd0, THR = 3'd1, LIM = 3'd2, CTL = 3'd3,
                         CNT = 3'd4, STA = 3'd5, IEN = 3'd6, IST = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pul = 2'b00;
  logic [1:0]  ctl = 2'b00;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  pulse_tally_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pul), .ctrl_i(ctl),
    .reg_addr_i(addr), .reg_wr_i(wr_en), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] which, input int hi, input int lo);
    @(negedge clk);
    pul = pul | which;
    repeat (hi) @(negedge clk);
    pul = pul & ~which;
    repeat (lo) @(negedge clk);
  endtask

  task automatic pulses(input logic [1:0] which, input int n);
    repeat (n) pulse(which, 2, 2);
    tick(3);
  endtask

  task automatic clr_all();
    wr(CTL, 32'd1);
    wr(CTL, 32'd0);
    wr(IST, 32'd1);
  endtask

  function automatic logic [7:0] chc(input int r, input int f, input int hm, input int lm);
    return {2'(lm), 2'(hm), 2'(f), 2'(r)};
  endfunction

  function automatic logic [31:0] mk_cfg(input logic [7:0] c0, input logic [7:0] c1,
                                         input logic [4:0] ev, input logic fen,
                                         input logic [9:0] fth);
    return {c1, c0, ev, fen, fth};
  endfunction

  function automatic int model_step(input int act, input int md);
    int v;
    v = (act == 1) ? 1 : ((act == 2) ? -1 : 0);
    if (md == 1) v = -v;
    else if (md != 0) v = 0;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int exp;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd(CNT, d); check("R1 tally", d, 32'd0);
    rd(STA, d); check("R1 status", d, 32'd0);
    rd(IST, d); check("R1 int status", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    wr(LIM, {16'd1000, 16'hFC18});

    // R2 R3: sweep of edge action x modifier x control level on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int r = 0; r < 3; r++)
        for (int f = 0; f < 3; f++)
          for (int hm = 0; hm < 3; hm++)
            for (int lm = 0; lm < 3; lm++)
              for (int lvl = 0; lvl < 2; lvl++) begin
                clr_all();
                if (ch == 0) wr(CFG, mk_cfg(chc(r, f, hm, lm), 8'h00, 5'd0, 1'b0, 10'd0));
                else         wr(CFG, mk_cfg(8'h00, chc(r, f, hm, lm), 5'd0, 1'b0, 10'd0));
                ctl = (lvl != 0) ? (2'b01 << ch) : 2'b00;
                tick(3);
                pulses(2'b01 << ch, 3);
                rd(CNT, d);
                exp = 3 * (model_step(r, (lvl != 0) ? hm : lm) + model_step(f, (lvl != 0) ? hm : lm));
                check($sformatf("R2 R3 ch%0d rise%0d fall%0d hm%0d lm%0d lvl%0d", ch, r, f, hm, lm, lvl),
                      d, 32'(exp));
              end
    ctl = 2'b00;
    tick(3);

    // R4 simultaneous steps add up
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), chc(1, 0, 0, 0), 5'd0, 1'b0, 10'd0));
    clr_all();
    pulses(2'b11, 5);
    rd(CNT, d); check("R4 both up", d, 32'd10);
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), chc(2, 0, 0, 0), 5'd0, 1'b0, 10'd0));
    clr_all();
    pulses(2'b11, 5);
    rd(CNT, d); check("R4 up and down cancel", d, 32'd0);

    // R5 glitch filter boundaries
    for (int k = 0; k < 3; k++) begin
      int th;
      th = (k == 0) ? 2 : ((k == 1) ? 3 : 5);
      wr(CFG, mk_cfg(chc(1, 0, 0, 0), 8'h00, 5'd0, 1'b1, 10'(th)));
      clr_all();
      pulse(2'b01, th - 1, th + 2);
      tick(3);
      rd(CNT, d); check($sformatf("R5 short pulse th%0d", th), d, 32'd0);
      pulse(2'b01, th, th + 2);
      tick(3);
      rd(CNT, d); check($sformatf("R5 exact pulse th%0d", th), d, 32'd1);
    end
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), 8'h00, 5'd0, 1'b0, 10'd5));
    clr_all();
    pulse(2'b01, 1, 3);
    tick(3);
    rd(CNT, d); check("R5 bypass one-cycle pulse", d, 32'd1);

    // R6 pause and clear
    clr_all();
    pulses(2'b01, 2);
    wr(CTL, 32'd2);
    pulses(2'b01, 3);
    rd(CNT, d); check("R6 paused", d, 32'd2);
    wr(CTL, 32'd0);
    pulses(2'b01, 1);
    rd(CNT, d); check("R6 resumed", d, 32'd3);
    wr(CTL, 32'd3);
    tick(2);
    rd(CNT, d); check("R6 clear beats pause", d, 32'd0);
    wr(CTL, 32'd0);

    // R13 negative readback
    wr(CFG, mk_cfg(chc(2, 0, 0, 0), 8'h00, 5'd0, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 3);
    rd(CNT, d); check("R13 sign extension", d, 32'hFFFF_FFFD);

    // R7 high limit
    wr(LIM, {16'd5, 16'hFC18});
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), 8'h00, 5'b01000, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 5);
    rd(CNT, d); check("R7 tally after high limit", d, 32'd0);
    rd(STA, d); check("R7 high flag", d & 32'h7C, 32'h20);

    // R8 low limit
    wr(LIM, {16'd1000, 16'hFFFD});
    wr(CFG, mk_cfg(chc(2, 0, 0, 0), 8'h00, 5'b00100, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 3);
    rd(CNT, d); check("R8 tally after low limit", d, 32'd0);
    rd(STA, d); check("R8 low flag", d & 32'h7C, 32'h10);

    // R9 thresholds: thr0 = 2, thr1 = -2
    wr(LIM, {16'd1000, 16'hFC18});
    wr(THR, {16'hFFFE, 16'd2});
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), chc(2, 0, 0, 0), 5'b00011, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 3);
    rd(STA, d); check("R9 threshold 0 only", d & 32'h7C, 32'h08);
    wr(IST, 32'd1);
    pulses(2'b10, 5);
    rd(CNT, d); check("R9 tally", d, 32'hFFFF_FFFE);
    rd(STA, d); check("R9 both thresholds", d & 32'h7C, 32'h0C);

    // R10 zero crossing codes
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), chc(2, 0, 0, 0), 5'b10000, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 2);
    pulses(2'b10, 2);
    rd(STA, d); check("R10 from positive", d & 32'h7F, 32'h40);
    clr_all();
    pulses(2'b10, 1);
    pulses(2'b01, 1);
    rd(STA, d); check("R10 from negative", d & 32'h7F, 32'h41);
    clr_all();
    pulses(2'b01, 1);
    wr(CFG, mk_cfg(chc(2, 0, 0, 0), chc(2, 0, 0, 0), 5'b10000, 1'b0, 10'd0));
    pulses(2'b11, 1);
    rd(CNT, d); check("R10 jump tally", d, 32'hFFFF_FFFF);
    rd(STA, d); check("R10 jump across", d & 32'h7F, 32'h43);
    wr(LIM, {16'd2, 16'hFC18});
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), chc(2, 0, 0, 0), 5'b10000, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 2);
    rd(STA, d); check("R10 limit return", d & 32'h7F, 32'h42);

    // R11 disabled watch points stay silent
    wr(LIM, {16'd3, 16'hFC18});
    wr(THR, {16'd1, 16'd1});
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), 8'h00, 5'b00000, 1'b0, 10'd0));
    clr_all();
    pulses(2'b01, 4);
    rd(STA, d); check("R11 no flags", d & 32'h7C, 32'h00);
    rd(IST, d); check("R11 no interrupt", d, 32'd0);

    // R12 interrupt enable, masking, write-one-to-clear
    wr(LIM, {16'd2, 16'hFC18});
    wr(CFG, mk_cfg(chc(1, 0, 0, 0), 8'h00, 5'b01000, 1'b0, 10'd0));
    wr(IEN, 32'd0);
    clr_all();
    pulses(2'b01, 2);
    rd(IST, d); check("R12 raw without enable", d, 32'd1);
    check("R12 irq masked", {31'd0, irq}, 32'd0);
    wr(IEN, 32'd1);
    rd(IST, d); check("R12 masked set", d, 32'd3);
    check("R12 irq high", {31'd0, irq}, 32'd1);
    wr(IST, 32'd1);
    rd(IST, d); check("R12 cleared", d, 32'd0);
    rd(STA, d); check("R12 flags cleared", d & 32'h7C, 32'h00);
    check("R12 irq low", {31'd0, irq}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule